// File: doc/BRIEF.md
# 8-Bit Accumulator ALU with Flags

This block is the arithmetic and logic engine of an 8-bit accumulator machine. Each request names an operation and supplies the accumulator byte, a second operand byte and the current carry, auxiliary carry and overflow flags. The block returns a result byte, a second result byte that is used by multiply and divide, and the three updated flags. Every result is registered, and `done_o` marks the cycle in which it appears.

Most operations finish one cycle after they are requested. Multiply and divide run on an iterative engine that retires two bits per clock. While that engine is working, `busy_o` is high and new requests are dropped. Register selection, memory operands and instruction decode belong to the surrounding core. That core keeps the flags and feeds them back on every request. A flag that an operation does not define is passed through unchanged.

Top module: `acc_alu`

## Requirements
- R1: While `rst_ni` is low, `res_o`, `res_b_o`, `c_o`, `ac_o`, `ov_o`, `done_o` and `busy_o` are all 0.
- R2: Add (`op_i`=0) returns a_i+b_i. Add-with-carry (`op_i`=1) returns a_i+b_i+c_i. For both, C is the carry out of bit 7 and AC is the carry out of bit 3. OV is set when both operands have the same sign bit and the result's sign bit differs from it.
- R3: Subtract-with-borrow (`op_i`=2) returns a_i-b_i-c_i. C is the borrow out of bit 7 and AC is the borrow out of the low nibble. OV is set when the operand sign bits differ and the result's sign bit differs from a_i's.
- R4: AND (3), OR (4) and XOR (5) combine a_i with b_i. Increment (6) and decrement (7) work modulo 256. Clear (8) gives 0 and complement (9) gives ~a_i. All of these copy c_i, ac_i and ov_i to the flag outputs.
- R5: Rotate left (10) and rotate right (12) rotate the 8 bits of a_i. Rotate left through carry (11) and rotate right through carry (13) rotate the 9 bits {c_i,a_i}, and c_o takes the bit that leaves the byte.
- R6: Nibble swap (14) exchanges a_i[7:4] with a_i[3:0] and leaves the flags unchanged.
- R7: Decimal adjust (15) first adds 6 when a_i[3:0]>9 or ac_i=1. It then adds 0x60 when the corrected upper nibble is >9 or the carry is 1. A carry out of either addition sets C. AC and OV pass through.
- R8: Decimal adjust never clears the carry: c_i=1 always gives c_o=1.
- R9: Multiply (16) puts the low byte of a_i*b_i on `res_o` and the high byte on `res_b_o`. It sets C=0, sets OV when the product exceeds 255, and keeps AC at its value at request time.
- R10: Divide (17) puts the quotient a_i/b_i on `res_o` and the remainder on `res_b_o`. It sets C=0 and OV=0. When b_i is 0 it sets C=0 and OV=1, and the two result bytes are undefined.
- R11: A single-cycle operation raises `done_o` in the cycle after the request. Multiply and divide raise `done_o` four cycles later than that, and `busy_o` stays high in between. `done_o` and `busy_o` are never high together.
- R12: A request made while `busy_o` is high is ignored. A request made in the cycle where `done_o` is high is accepted.
- R13: The unused codes 18 to 31 return a_i and pass all flags through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request strobe |
| op_i | input | 5 | Operation code |
| a_i | input | 8 | Accumulator operand |
| b_i | input | 8 | Second operand (B for multiply/divide) |
| c_i | input | 1 | Current carry flag |
| ac_i | input | 1 | Current auxiliary carry flag |
| ov_i | input | 1 | Current overflow flag |
| res_o | output | 8 | Result byte (A) |
| res_b_o | output | 8 | Second result byte (B) |
| c_o | output | 1 | Carry flag result |
| ac_o | output | 1 | Auxiliary carry flag result |
| ov_o | output | 1 | Overflow flag result |
| done_o | output | 1 | Result valid strobe |
| busy_o | output | 1 | Multiply/divide in progress |

## Verification
A new request can coincide with a multiply or divide that is still running or just finishing. The bench starts a multiply and then holds a request for an add through every busy cycle. The multiply result must come out untouched, with no extra `done_o`. The add is held into the cycle where the multiply reports done and must then be accepted, so its sum appears in the next cycle.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  parameter int unsigned DATA_W = 8;
  localparam int unsigned NIB_W = DATA_W / 2;

  typedef enum logic [4:0] {
    OP_ADD  = 5'd0,
    OP_ADDC = 5'd1,
    OP_SUBB = 5'd2,
    OP_AND  = 5'd3,
    OP_OR   = 5'd4,
    OP_XOR  = 5'd5,
    OP_INC  = 5'd6,
    OP_DEC  = 5'd7,
    OP_CLR  = 5'd8,
    OP_CPL  = 5'd9,
    OP_RL   = 5'd10,
    OP_RLC  = 5'd11,
    OP_RR   = 5'd12,
    OP_RRC  = 5'd13,
    OP_SWAP = 5'd14,
    OP_DA   = 5'd15,
    OP_MUL  = 5'd16,
    OP_DIV  = 5'd17
  } alu_op_e;
endpackage

// File: rtl/acc_alu_addsub.sv
module acc_alu_addsub #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         ci_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         c_o,
  output logic         ac_o,
  output logic         ov_o
);
  localparam int unsigned NW = W / 2;
  localparam int unsigned HW = W - NW;

  logic [W-1:0]  y;
  logic          cin;
  logic [NW:0]   lo;
  logic [HW-1:0] mid;
  logic [1:0]    top;
  logic          c7;

  // subtraction as a + ~b + ~borrow; carries invert into borrows
  always_comb begin
    y   = sub_i ? ~b_i : b_i;
    cin = sub_i ^ ci_i;
    lo  = {1'b0, a_i[NW-1:0]} + {1'b0, y[NW-1:0]} + {{NW{1'b0}}, cin};
    mid = {1'b0, a_i[W-2:NW]} + {1'b0, y[W-2:NW]} + {{(HW-1){1'b0}}, lo[NW]};
    c7  = mid[HW-1];
    top = {1'b0, a_i[W-1]} + {1'b0, y[W-1]} + {1'b0, c7};
    sum_o = {top[0], mid[HW-2:0], lo[NW-1:0]};
    c_o   = top[1] ^ sub_i;
    ac_o  = lo[NW] ^ sub_i;
    ov_o  = c7 ^ top[1];
  end
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int unsigned W = DATA_W
) (
  input  alu_op_e      op_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         c_i,
  input  logic         ac_i,
  input  logic         ov_i,
  output logic [W-1:0] res_o,
  output logic         c_o,
  output logic         ac_o,
  output logic         ov_o
);
  localparam int unsigned NW = W / 2;

  logic [W-1:0] as_sum;
  logic         as_c, as_ac, as_ov;
  logic         as_ci, as_sub;
  logic [W:0]   da_t1, da_t2;
  logic         da_c1, da_c2;

  assign as_ci  = (op_i == OP_ADD) ? 1'b0 : c_i;
  assign as_sub = (op_i == OP_SUBB);

  acc_alu_addsub #(.W(W)) u_addsub (
    .a_i  (a_i),
    .b_i  (b_i),
    .ci_i (as_ci),
    .sub_i(as_sub),
    .sum_o(as_sum),
    .c_o  (as_c),
    .ac_o (as_ac),
    .ov_o (as_ov)
  );

  // decimal adjust: low correction first, high test sees the corrected byte
  always_comb begin
    da_t1 = {1'b0, a_i};
    if (a_i[NW-1:0] > NW'(9) || ac_i) da_t1 = da_t1 + (W+1)'(6);
    da_c1 = c_i | da_t1[W];
    da_t2 = {1'b0, da_t1[W-1:0]};
    if (da_t1[W-1:NW] > (W-NW)'(9) || da_c1) da_t2 = da_t2 + (W+1)'(6 << NW);
    da_c2 = da_c1 | da_t2[W];
  end

  always_comb begin
    res_o = a_i;
    c_o   = c_i;
    ac_o  = ac_i;
    ov_o  = ov_i;
    unique case (op_i)
      OP_ADD, OP_ADDC, OP_SUBB: begin
        res_o = as_sum;
        c_o   = as_c;
        ac_o  = as_ac;
        ov_o  = as_ov;
      end
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_INC:  res_o = a_i + W'(1);
      OP_DEC:  res_o = a_i - W'(1);
      OP_CLR:  res_o = '0;
      OP_CPL:  res_o = ~a_i;
      OP_RL:   res_o = {a_i[W-2:0], a_i[W-1]};
      OP_RR:   res_o = {a_i[0], a_i[W-1:1]};
      OP_RLC: begin
        res_o = {a_i[W-2:0], c_i};
        c_o   = a_i[W-1];
      end
      OP_RRC: begin
        res_o = {c_i, a_i[W-1:1]};
        c_o   = a_i[0];
      end
      OP_SWAP: res_o = {a_i[NW-1:0], a_i[W-1:NW]};
      OP_DA: begin
        res_o = da_t2[W-1:0];
        c_o   = da_c2;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv #(
  parameter int unsigned W      = 8,
  parameter int unsigned STEP_W = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         start_i,
  input  logic         div_i,
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  output logic         busy_o,
  output logic         last_o,
  output logic [W-1:0] lo_o,
  output logic [W-1:0] hi_o,
  output logic         ovf_o
);
  localparam int unsigned STEPS = W / STEP_W;
  localparam int unsigned CNT_W = $clog2(STEPS + 1);
  localparam int unsigned PW    = 2 * W;
  localparam int unsigned RW    = W + 1;

  logic             busy_q, div_q;
  logic [CNT_W-1:0] cnt_q;
  logic [W-1:0]     opb_q, sh_q, sh_n;
  logic [PW-1:0]    acc_q, acc_n;
  logic [RW-1:0]    rem;

  // mul: opb = multiplicand, sh = multiplier (MSB digits first)
  // div: opb = divisor, sh = dividend shifting out / quotient shifting in
  always_comb begin
    rem = '0;
    if (div_q) begin
      rem  = acc_q[RW-1:0];
      sh_n = sh_q;
      for (int i = 0; i < STEP_W; i++) begin
        rem  = {rem[W-1:0], sh_n[W-1]};
        sh_n = {sh_n[W-2:0], 1'b0};
        if (rem >= {1'b0, opb_q}) begin
          rem     = rem - {1'b0, opb_q};
          sh_n[0] = 1'b1;
        end
      end
      acc_n = PW'(rem);
    end else begin
      acc_n = (acc_q << STEP_W) + PW'(opb_q) * PW'(sh_q[W-1 -: STEP_W]);
      sh_n  = sh_q << STEP_W;
    end
  end

  assign busy_o = busy_q;
  assign last_o = busy_q && (cnt_q == CNT_W'(1));
  assign lo_o   = div_q ? sh_n : acc_n[W-1:0];
  assign hi_o   = div_q ? acc_n[W-1:0] : acc_n[PW-1:W];
  assign ovf_o  = div_q ? (opb_q == '0) : (acc_n[PW-1:W] != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      div_q  <= 1'b0;
      cnt_q  <= '0;
      opb_q  <= '0;
      sh_q   <= '0;
      acc_q  <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      div_q  <= div_i;
      cnt_q  <= CNT_W'(STEPS);
      opb_q  <= div_i ? b_i : a_i;
      sh_q   <= div_i ? a_i : b_i;
      acc_q  <= '0;
    end else if (busy_q) begin
      acc_q <= acc_n;
      sh_q  <= sh_n;
      cnt_q <= cnt_q - CNT_W'(1);
      if (last_o) busy_q <= 1'b0;
    end
  end

  // R12: the top must never launch while an operation is in flight
  assert_no_restart_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !busy_q);
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int unsigned STEP_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              c_i,
  input  logic              ac_i,
  input  logic              ov_i,
  output logic [DATA_W-1:0] res_o,
  output logic [DATA_W-1:0] res_b_o,
  output logic              c_o,
  output logic              ac_o,
  output logic              ov_o,
  output logic              done_o,
  output logic              busy_o
);
  localparam int unsigned W = DATA_W;

  alu_op_e      op_e;
  logic         is_md, accept, md_start;
  logic [W-1:0] u_res;
  logic         u_c, u_ac, u_ov;
  logic         md_busy, md_last, md_ovf;
  logic [W-1:0] md_lo, md_hi;
  logic         ac_hold_q;
  logic [W-1:0] res_q, res_b_q;
  logic         c_q, ac_q, ov_q, done_q;

  assign op_e     = alu_op_e'(op_i);
  assign is_md    = (op_e == OP_MUL) || (op_e == OP_DIV);
  assign accept   = start_i && !md_busy;
  assign md_start = accept && is_md;

  acc_alu_unit #(.W(W)) u_unit (
    .op_i (op_e),
    .a_i  (a_i),
    .b_i  (b_i),
    .c_i  (c_i),
    .ac_i (ac_i),
    .ov_i (ov_i),
    .res_o(u_res),
    .c_o  (u_c),
    .ac_o (u_ac),
    .ov_o (u_ov)
  );

  acc_alu_muldiv #(.W(W), .STEP_W(STEP_W)) u_muldiv (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(md_start),
    .div_i  (op_e == OP_DIV),
    .a_i    (a_i),
    .b_i    (b_i),
    .busy_o (md_busy),
    .last_o (md_last),
    .lo_o   (md_lo),
    .hi_o   (md_hi),
    .ovf_o  (md_ovf)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ac_hold_q <= 1'b0;
      res_q     <= '0;
      res_b_q   <= '0;
      c_q       <= 1'b0;
      ac_q      <= 1'b0;
      ov_q      <= 1'b0;
      done_q    <= 1'b0;
    end else begin
      if (md_start) ac_hold_q <= ac_i;
      if (accept && !is_md) begin
        res_q   <= u_res;
        res_b_q <= b_i;
        c_q     <= u_c;
        ac_q    <= u_ac;
        ov_q    <= u_ov;
        done_q  <= 1'b1;
      end else if (md_last) begin
        res_q   <= md_lo;
        res_b_q <= md_hi;
        c_q     <= 1'b0;
        ac_q    <= ac_hold_q;
        ov_q    <= md_ovf;
        done_q  <= 1'b1;
      end else begin
        done_q  <= 1'b0;
      end
    end
  end

  assign res_o   = res_q;
  assign res_b_o = res_b_q;
  assign c_o     = c_q;
  assign ac_o    = ac_q;
  assign ov_o    = ov_q;
  assign done_o  = done_q;
  assign busy_o  = md_busy;

  assert_add_ov_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && (op_e == OP_ADD || op_e == OP_ADDC)) |=>
      (ov_o == (($past(a_i[W-1]) == $past(b_i[W-1])) && (res_o[W-1] != $past(a_i[W-1])))));

  assert_sub_ov_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_e == OP_SUBB) |=>
      (ov_o == (($past(a_i[W-1]) != $past(b_i[W-1])) && (res_o[W-1] != $past(a_i[W-1])))));

  assert_da_keep_c_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && op_e == OP_DA && c_i) |=> c_o);

  // R9 and R10: multiply and divide both finish with carry cleared
  assert_md_carry_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    md_last |=> (done_o && !c_o));

  assert_done_idle_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/acc_alu_bench.sv
module acc_alu_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [4:0] op = '0;
  logic [7:0] a = '0, b = '0;
  logic       c = 1'b0, ac = 1'b0, ov = 1'b0;
  logic [7:0] res, res_b;
  logic       c_o, ac_o, ov_o, done, busy;

  int nchk = 0;
  int nerr = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  acc_alu u_acc_alu (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .op_i(op),
    .a_i(a), .b_i(b), .c_i(c), .ac_i(ac), .ov_i(ov),
    .res_o(res), .res_b_o(res_b), .c_o(c_o), .ac_o(ac_o), .ov_o(ov_o),
    .done_o(done), .busy_o(busy)
  );

  task automatic chk(input string tag, input string what, input int got, input int exp);
    nchk++;
    if (got != exp) begin
      nerr++;
      $display("FAIL %s %s got %0h exp %0h", tag, what, got, exp);
    end
  endtask

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R2";
      2: return "R3";
      3, 4, 5, 6, 7, 8, 9: return "R4";
      10, 11, 12, 13: return "R5";
      14: return "R6";
      15: return "R7";
      16: return "R9";
      17: return "R10";
      default: return "R13";
    endcase
  endfunction

  function automatic void ref_model(input int o, input int ai, input int bi, input int ci,
                                    input int aci, input int ovi, output int r, output int rb,
                                    output int rc, output int rac, output int rov);
    int v, cc;
    r = ai; rb = bi; rc = ci; rac = aci; rov = ovi;
    case (o)
      0, 1: begin
        cc = (o == 1) ? ci : 0;
        v = ai + bi + cc;
        r = v & 255; rc = int'(v > 255);
        rac = int'(((ai & 15) + (bi & 15) + cc) > 15);
        rov = int'((ai[7] == bi[7]) && (r[7] != ai[7]));
      end
      2: begin
        v = ai - bi - ci;
        r = v & 255; rc = int'(v < 0);
        rac = int'(((ai & 15) - (bi & 15) - ci) < 0);
        rov = int'((ai[7] != bi[7]) && (r[7] != ai[7]));
      end
      3: r = ai & bi;
      4: r = ai | bi;
      5: r = ai ^ bi;
      6: r = (ai + 1) & 255;
      7: r = (ai + 255) & 255;
      8: r = 0;
      9: r = ~ai & 255;
      10: r = ((ai << 1) | (ai >> 7)) & 255;
      11: begin r = ((ai << 1) | ci) & 255; rc = ai[7]; end
      12: r = ((ai >> 1) | (ai << 7)) & 255;
      13: begin r = (ai >> 1) | (ci << 7); rc = ai[0]; end
      14: r = ((ai << 4) | (ai >> 4)) & 255;
      15: begin
        v = ai; cc = ci;
        if ((v & 15) > 9 || aci != 0) v = v + 6;
        if (v > 255) cc = 1;
        v = v & 255;
        if (((v >> 4) & 15) > 9 || cc != 0) v = v + 96;
        if (v > 255) cc = 1;
        r = v & 255; rc = cc;
      end
      16: begin
        v = ai * bi;
        r = v & 255; rb = v >> 8; rc = 0; rov = int'(v > 255);
      end
      17: begin
        rc = 0;
        if (bi == 0) rov = 1;
        else begin r = ai / bi; rb = ai % bi; rov = 0; end
      end
      default: ;
    endcase
  endfunction

  task automatic run_op(input int o, input int ai, input int bi, input int ci,
                        input int aci, input int ovi);
    int r, rb, rc, rac, rov, lat;
    string t;
    @(negedge clk);
    op = 5'(o); a = 8'(ai); b = 8'(bi); c = ci[0]; ac = aci[0]; ov = ovi[0];
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    lat = 1;
    while (!done && lat < 20) begin
      @(negedge clk);
      lat++;
    end
    ref_model(o, ai, bi, ci, aci, ovi, r, rb, rc, rac, rov);
    t = tag_of(o);
    chk("R11", "latency", lat, (o == 16 || o == 17) ? 5 : 1);
    if (!(o == 17 && bi == 0)) begin
      chk(t, "res", int'(res), r);
      chk(t, "res_b", int'(res_b), rb);
    end
    chk(t, "c", int'(c_o), rc);
    chk(t, "ac", int'(ac_o), rac);
    chk(t, "ov", int'(ov_o), rov);
    if (o == 15 && ci == 1) chk("R8", "da keeps c", int'(c_o), 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      nerr++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", nchk, nerr);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R1: reset state
    repeat (2) @(negedge clk);
    chk("R1", "res", int'(res), 0);
    chk("R1", "res_b", int'(res_b), 0);
    chk("R1", "flags", int'({c_o, ac_o, ov_o}), 0);
    chk("R1", "done", int'(done), 0);
    chk("R1", "busy", int'(busy), 0);
    rst_n = 1'b1;

    // directed corners
    run_op(0, 8'hFF, 8'h01, 0, 0, 0);
    run_op(0, 8'h7F, 8'h01, 0, 0, 0);
    run_op(1, 8'h80, 8'h80, 1, 0, 0);
    run_op(2, 8'h00, 8'h00, 1, 0, 0);
    run_op(2, 8'h80, 8'h01, 0, 0, 0);
    run_op(2, 8'h10, 8'h01, 0, 0, 0);
    run_op(11, 8'h80, 8'h00, 0, 1, 1);
    run_op(13, 8'h01, 8'h00, 1, 0, 0);
    run_op(14, 8'hA5, 8'h00, 1, 1, 0);
    run_op(16, 8'hFF, 8'hFF, 1, 1, 0);
    run_op(16, 8'h0F, 8'h10, 1, 0, 1);
    run_op(17, 8'hFF, 8'h07, 1, 0, 1);
    run_op(17, 8'h23, 8'h00, 1, 1, 0);
    run_op(17, 8'h05, 8'h09, 0, 0, 1);
    run_op(20, 8'h3C, 8'h11, 1, 0, 1);

    // R12: requests during busy dropped; request in done cycle accepted
    @(negedge clk);
    op = 5'd16; a = 8'h12; b = 8'h34; c = 1'b1; ac = 1'b1; ov = 1'b0; start = 1'b1;
    @(negedge clk);
    op = 5'd0; a = 8'h01; b = 8'h01; c = 1'b0; ac = 1'b0;
    for (int k = 0; k < 3; k++) begin
      chk("R11", "busy during mul", int'(busy), 1);
      chk("R12", "no done while busy", int'(done), 0);
      @(negedge clk);
    end
    chk("R12", "no done while busy", int'(done), 0);
    @(negedge clk);
    chk("R12", "mul done", int'(done), 1);
    chk("R12", "mul lo untouched", int'(res), 8'hA8);
    chk("R12", "mul hi untouched", int'(res_b), 8'h03);
    chk("R9", "mul keeps ac", int'(ac_o), 1);
    @(negedge clk);
    start = 1'b0;
    chk("R12", "add accepted at done", int'(done), 1);
    chk("R12", "add result", int'(res), 2);
    @(negedge clk);
    chk("R12", "single done", int'(done), 0);

    // R7 R8: exhaustive decimal adjust
    for (int v = 0; v < 256; v++)
      for (int f = 0; f < 4; f++)
        run_op(15, v, 0, f & 1, f >> 1, 0);

    // random over all codes
    for (int n = 0; n < 3000; n++)
      run_op(int'($urandom_range(0, 21)), int'($urandom_range(0, 255)),
             int'($urandom_range(0, 255)), int'($urandom_range(0, 1)),
             int'($urandom_range(0, 1)), int'($urandom_range(0, 1)));

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule